// File: doc/BRIEF.md
# Two-Channel Receive Flag and Interrupt Arbiter

This block sits between two byte queues, one fed by a keyboard channel and one by an auxiliary pointing-device channel, and the host side of an input controller. Each queue signals a data-available level. The block captures these levels as pending bits. From the pending bits and a registered copy of the controller mode byte it derives four outputs: the buffer-full flags for the status byte, the matching flags for the output port, and one interrupt request per channel.

A host read of the data port goes to one channel. The keyboard channel has priority. The auxiliary channel is chosen only when it is the only one with data. The read pops the chosen queue for one cycle and stores the byte in a read-data register. If the chosen queue is empty, the read pops nothing and the register keeps the last byte read. Queue storage and command decoding are handled by other blocks.

Top module: `rx_flag_arbiter`

## Requirements
- R1: The keyboard pending bit and the auxiliary pending bit each take the level of their channel's data-available input. The value is captured at the clock edge, and the derived outputs reflect it from the next cycle.
- R2: `stat_obf` (status bit 0) and `port_obf` (output port bit 4) are high exactly when at least one channel is pending.
- R3: `stat_aux_obf` (status bit 5) and `port_aux_obf` (output port bit 5) are high only when the auxiliary channel is pending and the keyboard channel is not.
- R4: `irq_aux` is high exactly when the auxiliary channel alone is pending and mode bit 1 is set.
- R5: `irq_kbd` is high exactly when the keyboard channel is pending, mode bit 0 is set and mode bit 4 (keyboard off) is clear. This holds whether or not auxiliary data is also pending.
- R6: `irq_kbd` and `irq_aux` are never both high. Both are low when nothing is pending.
- R7: `src_aux` is high only when the auxiliary channel alone is pending. When both channels are pending, the keyboard channel is selected.
- R8: In a cycle with `rd_strobe` high, exactly the selected channel gets a pop (`pop_kbd` or `pop_aux`), and only if that channel is pending. The other channel never gets a pop.
- R9: At the clock edge of a read that pops, `rd_data` loads the head byte of the popped channel. At every other edge, including a read of an empty selected channel, `rd_data` keeps its value.
- R10: A write to `mode_in` changes the interrupt outputs from the cycle after the edge that captures it.
- R11: While reset is asserted, all flags, interrupts, pops and `src_aux` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_avail | input | 1 | Keyboard queue has data |
| aux_avail | input | 1 | Auxiliary queue has data |
| mode_in | input | MODE_W | Controller mode byte |
| rd_strobe | input | 1 | Host reads the data port this cycle |
| kbd_head | input | DATA_W | Head byte of the keyboard queue |
| aux_head | input | DATA_W | Head byte of the auxiliary queue |
| stat_obf | output | 1 | Status: output buffer full |
| stat_aux_obf | output | 1 | Status: auxiliary buffer full |
| port_obf | output | 1 | Output port bit 4 |
| port_aux_obf | output | 1 | Output port bit 5 |
| irq_kbd | output | 1 | Keyboard interrupt request |
| irq_aux | output | 1 | Auxiliary interrupt request |
| src_aux | output | 1 | Data-port source is the auxiliary channel |
| pop_kbd | output | 1 | Pop the keyboard queue |
| pop_aux | output | 1 | Pop the auxiliary queue |
| rd_data | output | DATA_W | Last byte read from a queue |

## Verification
A wrong pending or mode register shows up in the flags and interrupts within one cycle of the input that should have set it. A wrong priority decision shows up twice: in `src_aux` and the pop lines during the read, and in `rd_data` one cycle later. A read-data register that drops or corrupts its held byte is detected at the first idle cycle or the first empty read that follows.

// File: rtl/rx_flag_pkg.sv
package rx_flag_pkg;
   typedef enum logic {
      SRC_KBD = 1'b0,
      SRC_AUX = 1'b1
   } src_e;

   typedef struct packed {
      logic obf;
      logic aux_obf;
      logic irq_kbd;
      logic irq_aux;
   } flag_t;
endpackage

// File: rtl/rx_pend_capture.sv
module rx_pend_capture #(
   parameter int STAGES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] avail,
   output logic [1:0] pend
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("rx_pend_capture: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         logic [1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= avail;
         end
         assign pend = q;
      end else begin : g_chain
         logic [1:0] q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) q[i] <= '0;
            end else begin
               q[0] <= avail;
               for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign pend = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rx_flag_logic.sv
module rx_flag_logic
   import rx_flag_pkg::*;
#(
   parameter int MODE_W      = 8,
   parameter int KBD_IRQ_BIT = 0,
   parameter int AUX_IRQ_BIT = 1,
   parameter int KBD_OFF_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        pend,
   input  logic [MODE_W-1:0] mode,
   output flag_t             flags,
   output src_e              src
);
   generate
      if (KBD_IRQ_BIT >= MODE_W || AUX_IRQ_BIT >= MODE_W || KBD_OFF_BIT >= MODE_W) begin : g_bad
         $error("rx_flag_logic: mode bit index outside MODE_W");
      end
   endgenerate

   logic kbd_p, aux_only;
   assign kbd_p    = pend[0];
   assign aux_only = pend[1] & ~pend[0];

   always_comb begin
      flags.obf     = |pend;
      flags.aux_obf = aux_only;
      flags.irq_aux = aux_only & mode[AUX_IRQ_BIT];
      flags.irq_kbd = kbd_p & mode[KBD_IRQ_BIT] & ~mode[KBD_OFF_BIT];
      src           = aux_only ? SRC_AUX : SRC_KBD;
   end

   // R6
   irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(flags.irq_kbd && flags.irq_aux));
   // R3
   aux_implies_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags.aux_obf |-> flags.obf);
   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flags.obf |-> !(flags.irq_kbd || flags.irq_aux));
endmodule

// File: rtl/rx_read_steer.sv
module rx_read_steer
   import rx_flag_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  src_e              src,
   input  logic [1:0]        pend,
   input  logic [DATA_W-1:0] kbd_head,
   input  logic [DATA_W-1:0] aux_head,
   output logic              pop_kbd,
   output logic              pop_aux,
   output logic [DATA_W-1:0] rd_data
);
   always_comb begin
      pop_kbd = rd_strobe && (src == SRC_KBD) && pend[0];
      pop_aux = rd_strobe && (src == SRC_AUX) && pend[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_data <= '0;
      else if (pop_kbd) rd_data <= kbd_head;
      else if (pop_aux) rd_data <= aux_head;
   end

   // R8
   pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pop_kbd, pop_aux}));
   // R8
   pop_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_kbd || pop_aux) |-> rd_strobe);
   // R9
   kbd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_kbd |=> rd_data == $past(kbd_head));
   // R9
   aux_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_aux |=> rd_data == $past(aux_head));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop_kbd || pop_aux) |=> $stable(rd_data));
endmodule

// File: rtl/rx_flag_arbiter.sv
module rx_flag_arbiter
   import rx_flag_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int MODE_W      = 8,
   parameter int KBD_IRQ_BIT = 0,
   parameter int AUX_IRQ_BIT = 1,
   parameter int KBD_OFF_BIT = 4,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kbd_avail,
   input  logic              aux_avail,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              rd_strobe,
   input  logic [DATA_W-1:0] kbd_head,
   input  logic [DATA_W-1:0] aux_head,
   output logic              stat_obf,
   output logic              stat_aux_obf,
   output logic              port_obf,
   output logic              port_aux_obf,
   output logic              irq_kbd,
   output logic              irq_aux,
   output logic              src_aux,
   output logic              pop_kbd,
   output logic              pop_aux,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("rx_flag_arbiter: DATA_W must be positive");
      end
   endgenerate

   logic [1:0]        pend;
   logic [MODE_W-1:0] mode_q;
   flag_t             flags;
   src_e              src;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= '0;
      else        mode_q <= mode_in;
   end

   rx_pend_capture #(.STAGES(SYNC_STAGES)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .avail ({aux_avail, kbd_avail}),
      .pend  (pend)
   );

   rx_flag_logic #(
      .MODE_W      (MODE_W),
      .KBD_IRQ_BIT (KBD_IRQ_BIT),
      .AUX_IRQ_BIT (AUX_IRQ_BIT),
      .KBD_OFF_BIT (KBD_OFF_BIT)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .mode  (mode_q),
      .flags (flags),
      .src   (src)
   );

   rx_read_steer #(.DATA_W(DATA_W)) u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_strobe (rd_strobe),
      .src       (src),
      .pend      (pend),
      .kbd_head  (kbd_head),
      .aux_head  (aux_head),
      .pop_kbd   (pop_kbd),
      .pop_aux   (pop_aux),
      .rd_data   (rd_data)
   );

   assign stat_obf     = flags.obf;
   assign port_obf     = flags.obf;
   assign stat_aux_obf = flags.aux_obf;
   assign port_aux_obf = flags.aux_obf;
   assign irq_kbd      = flags.irq_kbd;
   assign irq_aux      = flags.irq_aux;
   assign src_aux      = (src == SRC_AUX);

   // R10
   mode_kbd_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_kbd |-> mode_q[KBD_IRQ_BIT] && !mode_q[KBD_OFF_BIT]);
   // R7
   src_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_aux |-> !pop_kbd);
endmodule

// File: tb/rx_flag_arbiter_test.sv
module rx_flag_arbiter_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       kbd_avail, aux_avail, rd_strobe;
   logic [7:0] mode_in, kbd_head, aux_head;
   logic       stat_obf, stat_aux_obf, port_obf, port_aux_obf;
   logic       irq_kbd, irq_aux, src_aux, pop_kbd, pop_aux;
   logic [7:0] rd_data;

   int n_cmp = 0;
   int n_bad = 0;

   // model state
   bit       m_pk, m_pa;
   bit [7:0] m_mode, m_rd;

   always #4 clk = ~clk;

   rx_flag_arbiter uut (
      .clk(clk), .rst_n(rst_n), .kbd_avail(kbd_avail), .aux_avail(aux_avail),
      .mode_in(mode_in), .rd_strobe(rd_strobe), .kbd_head(kbd_head),
      .aux_head(aux_head), .stat_obf(stat_obf), .stat_aux_obf(stat_aux_obf),
      .port_obf(port_obf), .port_aux_obf(port_aux_obf), .irq_kbd(irq_kbd),
      .irq_aux(irq_aux), .src_aux(src_aux), .pop_kbd(pop_kbd),
      .pop_aux(pop_aux), .rd_data(rd_data)
   );

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // compare all outputs with the model for the current inputs
   task automatic compare_all();
      bit any, aonly, ek, ea, pk, pa;
      any   = m_pk | m_pa;
      aonly = m_pa & ~m_pk;
      ek    = m_pk & m_mode[0] & ~m_mode[4];
      ea    = aonly & m_mode[1];
      pk    = rd_strobe & ~aonly & m_pk;
      pa    = rd_strobe & aonly;
      chk("R2 stat_obf",      stat_obf, any);
      chk("R2 port_obf",      port_obf, any);
      chk("R3 stat_aux_obf",  stat_aux_obf, aonly);
      chk("R3 port_aux_obf",  port_aux_obf, aonly);
      chk("R5/R10 irq_kbd",   irq_kbd, ek);
      chk("R4/R10 irq_aux",   irq_aux, ea);
      chk("R6 irq_exclusive", irq_kbd & irq_aux, 0);
      chk("R7 src_aux",       src_aux, aonly);
      chk("R8 pop_kbd",       pop_kbd, pk);
      chk("R8 pop_aux",       pop_aux, pa);
      chk("R9 rd_data",       rd_data, m_rd);
   endtask

   // one cycle: inputs already driven after negedge
   task automatic step(bit k, bit a, bit [7:0] md, bit rd, bit [7:0] kh, bit [7:0] ah);
      bit aonly;
      kbd_avail = k; aux_avail = a; mode_in = md; rd_strobe = rd;
      kbd_head = kh; aux_head = ah;
      #2;
      compare_all();
      aonly = m_pa & ~m_pk;
      @(posedge clk);
      if (rd && !aonly && m_pk) m_rd = kh;
      else if (rd && aonly)     m_rd = ah;
      m_pk = k; m_pa = a; m_mode = md;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #400000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      kbd_avail = 0; aux_avail = 0; mode_in = 8'h03; rd_strobe = 1;
      kbd_head = 8'h11; aux_head = 8'h22;
      m_pk = 0; m_pa = 0; m_mode = 0; m_rd = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state, even with inputs active
      kbd_avail = 1; aux_avail = 1;
      @(posedge clk);
      @(negedge clk);
      compare_all();
      rst_n = 1'b1;

      // R1 R2 R5 keyboard alone, default mode
      step(1, 0, 8'h03, 0, 8'h00, 8'h00);
      step(1, 0, 8'h03, 0, 8'h00, 8'h00);
      // R8 R9 keyboard read
      step(1, 0, 8'h03, 1, 8'hA5, 8'h5A);
      // R3 R4 auxiliary alone
      step(0, 1, 8'h03, 0, 8'h00, 8'h00);
      step(0, 1, 8'h03, 1, 8'h01, 8'hC3);
      // R7 both pending: keyboard wins
      step(1, 1, 8'h03, 0, 8'h00, 8'h00);
      step(1, 1, 8'h03, 1, 8'h77, 8'h88);
      step(1, 1, 8'h03, 1, 8'h78, 8'h89);
      // R5 keyboard off bit masks irq; R10 mode change timing
      step(1, 0, 8'h13, 0, 8'h00, 8'h00);
      step(1, 0, 8'h13, 0, 8'h00, 8'h00);
      step(1, 0, 8'h03, 0, 8'h00, 8'h00);
      step(0, 1, 8'h01, 0, 8'h00, 8'h00);
      step(0, 1, 8'h01, 0, 8'h00, 8'h00);
      // R9 empty read keeps last byte, no pop
      step(0, 0, 8'h03, 1, 8'hEE, 8'hDD);
      step(0, 0, 8'h03, 1, 8'hEF, 8'hDC);
      step(0, 0, 8'h03, 0, 8'h00, 8'h00);
      // mixed pseudo-random traffic covering all requirements
      for (int i = 0; i < 600; i++) begin
         bit [7:0] md;
         md = 8'($urandom) & 8'h13;
         step(1'($urandom), 1'($urandom), md, 1'($urandom), 8'($urandom), 8'($urandom));
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule